// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers up to eight interrupt lines and raises one interrupt request towards a processor. Priority is fixed, and line 0 is the most urgent. Each line has a request latch, a mask bit and an in-service bit. A rising edge on a line sets its latch. The processor answers the interrupt output with an acknowledge pulse. The controller then moves the winning request into the in-service set and reports its level number.

Nesting is tracked. A more urgent line can interrupt a handler that is already running for a less urgent line. A line that is in service cannot interrupt again until software retires it. Software uses a small register bus for three things: it writes the mask, it retires levels with end-of-interrupt commands, and it reads back the request, mask and in-service sets. A non-specific end-of-interrupt retires only the most urgent level that is in service. The other nested levels stay in service, so a handler that sends this command cannot reopen a handler that is still running further down.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset the mask reads 0xFF, the request and in-service sets read 0x00, and `irq_out` is 0.
- R2: A 0-to-1 transition on `irq_in[k]` sets request bit k. A line that stays high posts only one request, so after that request is acknowledged and retired the request bit stays 0.
- R3: Register reads have one cycle of latency. `bus_rdata` returns the request set for address 0, the mask for address 1, the in-service set for address 2, and 0 for address 3. Bit k of each value belongs to line k.
- R4: When `int_ack` is high and `irq_out` is high, the lowest-numbered pending unmasked line is cleared from the request set and set in the in-service set. Its number appears on `ack_level` one cycle later.
- R5: `irq_out` is 1 exactly when some pending unmasked line has a lower number than every in-service line. A new request on a level that is already in service stays pending without raising `irq_out`.
- R6: A write to address 1 loads the mask. A bit value of 1 hides that line's request from `irq_out` but keeps it latched. Clearing the bit presents the request again.
- R7: Command 0x20 written to address 0 clears only the lowest-numbered in-service bit. For example, 0x21 becomes 0x20.
- R8: Command 0x60 | L written to address 0 (bits 7..3 = 01100, bits 2..0 = L) clears only in-service bit L.
- R9: `int_ack` while `irq_out` is 0 leaves the in-service and request sets unchanged.
- R10: An acknowledge and an end-of-interrupt command in the same cycle both take effect.
- R11: Writes to address 0 with any other code leave the in-service set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Edge-sensitive interrupt lines |
| int_ack | input | 1 | Acknowledge pulse from the processor |
| irq_out | output | 1 | Registered interrupt request to the processor |
| ack_level | output | LVL_W | Level granted by the most recent acknowledge |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
Two functions can coincide: an acknowledge that grants a new, more urgent level, and a non-specific end-of-interrupt that retires the current most urgent level. The bench sets up level 4 in service with level 1 pending. It then pulses `int_ack` in the same cycle as it writes command 0x20. The expected result is that the in-service set reads exactly 0x02 and `ack_level` reads 1. This shows the retire acts on the old set and the grant adds the new bit, without either cancelling the other.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned BUS_W = 8;
  localparam logic [7:0] CMD_EOI_TOP = 8'h20;
  localparam logic [4:0] CMD_EOI_LVL = 5'b01100;
  localparam logic [1:0] ADR_REQ_CMD = 2'd0;
  localparam logic [1:0] ADR_MASK    = 2'd1;
  localparam logic [1:0] ADR_SERVICE = 2'd2;
endpackage

// File: rtl/edge_latch.sv
module edge_latch #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;
  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) prev_q[g] <= 1'b0;
      else     prev_q[g] <= din[g];
    end
    assign rise[g] = din[g] & ~prev_q[g];
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [LW-1:0] lvl,
  output logic          vld
);
  always_comb begin
    lvl = '0;
    vld = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        lvl = LW'(i);
        vld = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import irq_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  input  logic [LW-1:0]    top_lvl,
  input  logic             top_vld,
  output logic [N-1:0]     clr_vec,
  output logic             mask_we,
  output logic [N-1:0]     mask_d
);
  logic cmd_we;
  assign cmd_we  = bus_wr && (bus_addr == ADR_REQ_CMD);
  assign mask_we = bus_wr && (bus_addr == ADR_MASK);
  assign mask_d  = bus_wdata[N-1:0];

  always_comb begin
    clr_vec = '0;
    if (cmd_we) begin
      if (bus_wdata == CMD_EOI_TOP) begin
        if (top_vld) clr_vec[top_lvl] = 1'b1;
      end else if (bus_wdata[7:3] == CMD_EOI_LVL) begin
        clr_vec[bus_wdata[LW-1:0]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned LVL_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 int_ack,
  output logic                 irq_out,
  output logic [LVL_W-1:0]     ack_level,
  input  logic [1:0]           bus_addr,
  input  logic                 bus_wr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata
);
  logic [NUM_LINES-1:0] irr_q, isr_q, mask_q;
  logic [NUM_LINES-1:0] irr_n, isr_n, mask_n;
  logic [NUM_LINES-1:0] rise, clr_vec, grant_vec, mask_d;
  logic                 mask_we, grant, irq_q, irq_n;
  logic [LVL_W-1:0]     p_lvl, s_lvl, pn_lvl, sn_lvl, lvl_q;
  logic                 p_vld, s_vld, pn_vld, sn_vld;
  logic [BUS_W-1:0]     rd_n, rd_q;

  edge_latch #(.N(NUM_LINES)) u_edge (
    .clk(clk), .rst(rst), .din(irq_in), .rise(rise)
  );

  prio_pick #(.N(NUM_LINES), .LW(LVL_W)) u_pick_pend (
    .vec(irr_q & ~mask_q), .lvl(p_lvl), .vld(p_vld)
  );
  prio_pick #(.N(NUM_LINES), .LW(LVL_W)) u_pick_svc (
    .vec(isr_q), .lvl(s_lvl), .vld(s_vld)
  );

  cmd_decode #(.N(NUM_LINES), .LW(LVL_W)) u_cmd (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .top_lvl(s_lvl), .top_vld(s_vld),
    .clr_vec(clr_vec), .mask_we(mask_we), .mask_d(mask_d)
  );

  assign grant = int_ack & irq_q;

  always_comb begin
    grant_vec = '0;
    if (grant && p_vld) grant_vec[p_lvl] = 1'b1;
  end

  assign irr_n  = (irr_q & ~grant_vec) | rise;
  assign isr_n  = (isr_q & ~clr_vec) | grant_vec;
  assign mask_n = mask_we ? mask_d : mask_q;

  prio_pick #(.N(NUM_LINES), .LW(LVL_W)) u_pick_pend_n (
    .vec(irr_n & ~mask_n), .lvl(pn_lvl), .vld(pn_vld)
  );
  prio_pick #(.N(NUM_LINES), .LW(LVL_W)) u_pick_svc_n (
    .vec(isr_n), .lvl(sn_lvl), .vld(sn_vld)
  );

  assign irq_n = pn_vld && (!sn_vld || (pn_lvl < sn_lvl));

  always_comb begin
    rd_n = '0;
    case (bus_addr)
      ADR_REQ_CMD: rd_n[NUM_LINES-1:0] = irr_q;
      ADR_MASK:    rd_n[NUM_LINES-1:0] = mask_q;
      ADR_SERVICE: rd_n[NUM_LINES-1:0] = isr_q;
      default:     rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q  <= '0;
      isr_q  <= '0;
      mask_q <= '1;
      irq_q  <= 1'b0;
      lvl_q  <= '0;
      rd_q   <= '0;
    end else begin
      irr_q  <= irr_n;
      isr_q  <= isr_n;
      mask_q <= mask_n;
      irq_q  <= irq_n;
      rd_q   <= rd_n;
      if (grant) lvl_q <= p_lvl;
    end
  end

  assign irq_out   = irq_q;
  assign ack_level = lvl_q;
  assign bus_rdata = rd_q;
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input logic          clk,
  input logic          rst,
  input logic          int_ack,
  input logic          irq_out,
  input logic [LW-1:0] ack_level,
  input logic          bus_wr,
  input logic [1:0]    bus_addr,
  input logic [7:0]    bus_wdata,
  input logic [N-1:0]  irr,
  input logic [N-1:0]  isr,
  input logic [N-1:0]  mask
);
  logic [N-1:0] below_top;
  assign below_top = (isr & (~isr + 1'b1)) - 1'b1;

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (irr == '0 && isr == '0 && mask == '1 && !irq_out));

  // R4
  a_r4_ack_in_service: assert property (@(posedge clk) disable iff (rst)
    (int_ack && irq_out) |=> isr[ack_level]);

  // R5
  a_r5_irq_outranks: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (isr == '0 ? ((irr & ~mask) != '0)
                           : ((irr & ~mask & below_top) != '0)));

  // R7
  a_r7_one_bit_retired: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd0 && bus_wdata == 8'h20 && isr != '0 &&
     !(int_ack && irq_out))
    |=> ($countones(isr) + 1 == $countones($past(isr))));

  // R9
  a_r9_idle_ack: assert property (@(posedge clk) disable iff (rst)
    (int_ack && !irq_out && !bus_wr) |=> (isr == $past(isr)));
endmodule

bind prio_irq_ctrl irq_ctrl_checker #(.N(NUM_LINES), .LW(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .int_ack(int_ack), .irq_out(irq_out),
  .ack_level(ack_level), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irr(irr_q), .isr(isr_q), .mask(mask_q)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       int_ack = 1'b0;
  logic       irq_out;
  logic [2:0] ack_level;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.NUM_LINES(8)) i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .int_ack(int_ack),
    .irq_out(irq_out), .ack_level(ack_level), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // ops: 1 pulse lines, 2 acknowledge, 3 command, 4 write mask,
  //      5 read in-service, 6 read request. {op, arg, expected}
  localparam logic [19:0] VEC [22] = '{
    20'h4_00_00,  // unmask all, R6
    20'h1_20_01,  // line 5 edge, R2 R5
    20'h2_00_05,  // grant 5, R4
    20'h5_00_20,  // R3
    20'h1_20_00,  // same level blocked, R5
    20'h6_00_20,  // still pending, R5
    20'h1_01_01,  // line 0 pre-empts, R5
    20'h2_00_00,  // grant 0, R4
    20'h5_00_21,  // nested set
    20'h3_20_00,  // non-specific retire, R7
    20'h5_00_20,  // only bit 0 gone, R7
    20'h3_65_01,  // specific retire of 5, R8
    20'h2_00_05,
    20'h5_00_20,
    20'h3_20_00,
    20'h4_04_00,  // mask line 2, R6
    20'h1_04_00,
    20'h6_00_04,  // latched while masked, R6
    20'h4_00_01,  // unmask presents it, R6
    20'h2_00_02,
    20'h3_62_00,  // R8
    20'h5_00_00
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] m);
    irq_in = irq_in | m;
    step();
    irq_in = irq_in & ~m;
  endtask

  task automatic ack();
    int_ack = 1'b1;
    step();
    int_ack = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    step();
    d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    check("R1 irq_out", {7'd0, irq_out}, 8'h00);
    rd(2'd1, v); check("R1 mask", v, 8'hFF);
    rd(2'd0, v); check("R1 request", v, 8'h00);
    rd(2'd2, v); check("R1 in-service", v, 8'h00);
    rd(2'd3, v); check("R3 spare address", v, 8'h00);

    for (int i = 0; i < 22; i++) begin
      logic [3:0] op;
      logic [7:0] arg, exp;
      {op, arg, exp} = VEC[i];
      case (op)
        4'd1: begin pulse(arg); check("R5 irq after edge", {7'd0, irq_out}, exp); end
        4'd2: begin ack(); check("R4 ack level", {5'd0, ack_level}, exp); end
        4'd3: begin wr(2'd0, arg); check("R7/R8 irq after retire", {7'd0, irq_out}, exp); end
        4'd4: begin wr(2'd1, arg); check("R6 irq after mask", {7'd0, irq_out}, exp); end
        4'd5: begin rd(2'd2, v); check("R3 in-service read", v, exp); end
        default: begin rd(2'd0, v); check("R2 request read", v, exp); end
      endcase
    end

    // R2: held line posts once
    irq_in[3] = 1'b1;
    repeat (4) step();
    check("R2 held line irq", {7'd0, irq_out}, 8'h01);
    ack();
    check("R2 held line level", {5'd0, ack_level}, 8'h03);
    wr(2'd0, 8'h20);
    step();
    check("R2 no second request", {7'd0, irq_out}, 8'h00);
    rd(2'd0, v); check("R2 request clear while high", v, 8'h00);
    irq_in[3] = 1'b0;

    // R9: acknowledge with nothing to grant
    ack();
    rd(2'd2, v); check("R9 in-service after idle ack", v, 8'h00);
    rd(2'd0, v); check("R9 request after idle ack", v, 8'h00);

    // R10: grant and non-specific retire together
    pulse(8'h10);
    ack();
    check("R10 setup level", {5'd0, ack_level}, 8'h04);
    pulse(8'h02);
    check("R10 pre-empt ready", {7'd0, irq_out}, 8'h01);
    int_ack = 1'b1;
    wr(2'd0, 8'h20);
    int_ack = 1'b0;
    check("R10 ack level", {5'd0, ack_level}, 8'h01);
    rd(2'd2, v); check("R10 in-service", v, 8'h02);

    // R11: unknown codes ignored
    wr(2'd0, 8'h40);
    wr(2'd0, 8'h00);
    rd(2'd2, v); check("R11 in-service after unknown codes", v, 8'h02);

    // R8: specific retire of a non-top level
    pulse(8'h01);
    ack();
    rd(2'd2, v); check("R8 setup", v, 8'h03);
    wr(2'd0, 8'h61);
    rd(2'd2, v); check("R8 specific retire", v, 8'h01);
    wr(2'd0, 8'h20);
    rd(2'd2, v); check("R7 last level retired", v, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule